// File: doc/BRIEF.md
# Supply Reset Pulse Stretcher

This block produces the reset for a processor from two digital causes. The first is a supply-low flag from an external voltage comparator. The second is an active-low manual request, for example from a pushbutton. While either cause is present, reset is asserted at once. The supply path has no clock in its way. The manual path passes only through an optional synchronizer.

When every cause has cleared, a counter on a free-running clock holds reset for a fixed number of cycles and then releases it. Any new cause during that interval clears the counter, so the interval always runs from the cause that clears last. The same mechanism debounces a bouncing pushbutton. The block drives the reset in two polarities: active low and active high.

The interval is the parameter `STRETCH_CYCLES`. Its default is 200 ms at a 50 MHz clock, inside the 140 ms to 280 ms window that is allowed. `SYNC_STAGES` selects a two-flop synchronizer for the manual input (2, the default) or direct use of an input that is already synchronous (0). The house reset `rst` is synchronous and active high. It stands for power-up, and reset is held throughout it.

Top module: `supply_reset_stretch`

## Requirements
- R1: While `supply_low` is 1, `sys_rst_n` is 0 in the same cycle, with no clock edge needed.
- R2: With `SYNC_STAGES` = 2, a 0 on `man_rst_n` that is driven between two edges makes `sys_rst_n` 0 after exactly two rising edges. With `SYNC_STAGES` = 0 it does so in the same cycle.
- R3: Take the first rising edge at which no cause is seen. `sys_rst_n` stays 0 until that edge and for `STRETCH_CYCLES`-1 further edges. It goes to 1 just after the `STRETCH_CYCLES`-th edge.
- R4: `sys_rst` is always the exact complement of `sys_rst_n`.
- R5: While `rst` is 1, `sys_rst_n` is 0. After `rst` falls, the full stretch interval still runs before release.
- R6: A manual low that is seen while the interval is running clears the count. Release then comes a full `STRETCH_CYCLES` after that low clears, so bounce is absorbed.
- R7: A manual low that lasts a single clock cycle is recognized and produces a complete reset pulse.
- R8: When both causes overlap, the interval is timed from whichever cause clears last.
- R9: Once released with no cause present, `sys_rst_n` stays 1. The counter saturates at `STRETCH_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| supply_low | input | 1 | Supply-below-threshold flag from comparator |
| man_rst_n | input | 1 | Active-low manual reset request |
| sys_rst_n | output | 1 | Active-low processor reset |
| sys_rst | output | 1 | Active-high processor reset |

## Verification
The bench pins the exact release cycle. A counter that is off by one would release reset one cycle early or late. A synchronizer with the wrong depth would shift the manual assertion.

A single-cycle glitch inside a running interval must push the release out by a full interval. A design that only stretched from the first release would let reset go early.

Overlapping causes are released in both orders. A design that timed the interval from the first cause to clear would release before the second has had its full interval.

A one-cycle manual pulse from the idle state must produce a complete pulse. A design that filtered short lows would miss it.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    // Allowed window of the stretch interval, in milliseconds
    localparam int unsigned STRETCH_MIN_MS = 140;
    localparam int unsigned STRETCH_NOM_MS = 200;
    localparam int unsigned STRETCH_MAX_MS = 280;

    // Progress of the stretch timer
    typedef enum logic [1:0] {
        PH_HOLD    = 2'd0,  // a cause is present, count held at zero
        PH_STRETCH = 2'd1,  // causes clear, counting up
        PH_DONE    = 2'd2   // terminal count reached, reset released
    } phase_e;

    // Active-high view of each reset cause
    typedef struct packed {
        logic supply;
        logic manual;
    } cause_t;

    function automatic int unsigned cycles_for_ms(input int unsigned ms,
                                                  input int unsigned clk_khz);
        return ms * clk_khz;
    endfunction

    function automatic logic any_cause(input cause_t c);
        return c.supply | c.manual;
    endfunction

endpackage

// File: rtl/rsp_sync.sv
module rsp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sh <= '1;                 // idle level: no request
                end else begin
                    sh[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        sh[i] <= sh[i-1];
                    end
                end
            end
            assign q = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rsp_timer.sv
module rsp_timer
    import rsp_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 20,
    parameter int unsigned CNT_W          = $clog2(STRETCH_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    output logic [CNT_W-1:0] cnt,
    output logic             done,
    output phase_e           phase
);
    localparam logic [CNT_W-1:0] TERMINAL = CNT_W'(STRETCH_CYCLES);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt <= '0;
        end else if (cnt != TERMINAL) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == TERMINAL);

    always_comb begin
        if (hold)      phase = PH_HOLD;
        else if (done) phase = PH_DONE;
        else           phase = PH_STRETCH;
    end
endmodule

// File: rtl/rsp_outdrv.sv
module rsp_outdrv
    import rsp_pkg::*;
(
    input  logic   rst,
    input  cause_t cause,
    input  phase_e phase,
    output logic   sys_rst_n,
    output logic   sys_rst
);
    logic active;

    // Causes feed the output directly, so assertion never waits on the timer
    always_comb begin
        active = rst | any_cause(cause) | (phase != PH_DONE);
    end

    assign sys_rst   = active;
    assign sys_rst_n = ~active;
endmodule

// File: rtl/supply_reset_stretch.sv
module supply_reset_stretch
    import rsp_pkg::*;
#(
    parameter int unsigned CLK_KHZ        = 50_000,
    parameter int unsigned STRETCH_CYCLES = cycles_for_ms(STRETCH_NOM_MS, CLK_KHZ),
    parameter int          SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_low,
    input  logic man_rst_n,
    output logic sys_rst_n,
    output logic sys_rst
);
    localparam int unsigned CNT_W = $clog2(STRETCH_CYCLES + 1);

    logic             man_q;
    cause_t           cause;
    logic             cause_any;
    logic [CNT_W-1:0] stretch_cnt;
    logic             stretch_done;
    phase_e           phase;

    rsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (man_rst_n),
        .q   (man_q)
    );

    always_comb begin
        cause.supply = supply_low;
        cause.manual = ~man_q;
        cause_any    = any_cause(cause);
    end

    rsp_timer #(
        .STRETCH_CYCLES(STRETCH_CYCLES),
        .CNT_W         (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .hold  (cause_any),
        .cnt   (stretch_cnt),
        .done  (stretch_done),
        .phase (phase)
    );

    rsp_outdrv u_out (
        .rst       (rst),
        .cause     (cause),
        .phase     (phase),
        .sys_rst_n (sys_rst_n),
        .sys_rst   (sys_rst)
    );
endmodule

// File: rtl/rsp_checker.sv
module rsp_checker #(
    parameter int unsigned STRETCH_CYCLES = 20,
    parameter int unsigned CNT_W          = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             supply_low,
    input logic             cause_any,
    input logic [CNT_W-1:0] stretch_cnt,
    input logic             sys_rst_n,
    input logic             sys_rst
);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(STRETCH_CYCLES);

    a_r1_supply_forces: assert property (@(posedge clk) disable iff (rst)
        supply_low |-> !sys_rst_n);

    a_r4_complement: assert property (@(posedge clk) disable iff (rst)
        sys_rst != sys_rst_n);

    a_r6_cause_clears_count: assert property (@(posedge clk) disable iff (rst)
        cause_any |=> (stretch_cnt == '0));

    a_r3_count_steps: assert property (@(posedge clk) disable iff (rst)
        (!cause_any && stretch_cnt != TERM) |=>
            (stretch_cnt == CNT_W'($past(stretch_cnt) + 1'b1)));

    a_r3_release_needs_terminal: assert property (@(posedge clk) disable iff (rst)
        sys_rst_n |-> (stretch_cnt == TERM && !cause_any));

    a_r9_saturates: assert property (@(posedge clk) disable iff (rst)
        (!cause_any && stretch_cnt == TERM) |=> (stretch_cnt == TERM));
endmodule

bind supply_reset_stretch rsp_checker #(
    .STRETCH_CYCLES(STRETCH_CYCLES),
    .CNT_W         (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .supply_low  (supply_low),
    .cause_any   (cause_any),
    .stretch_cnt (stretch_cnt),
    .sys_rst_n   (sys_rst_n),
    .sys_rst     (sys_rst)
);

// File: tb/supply_reset_stretch_test.sv
module supply_reset_stretch_test;
    localparam int S = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_low = 1'b0;
    logic man_rst_n = 1'b1;
    logic sys_rst_n, sys_rst;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int    at;
        bit    val;
        string req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;                // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    supply_reset_stretch #(.STRETCH_CYCLES(S), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .supply_low(supply_low), .man_rst_n(man_rst_n),
        .sys_rst_n(sys_rst_n), .sys_rst(sys_rst)
    );

    // driver side: queue an expected sys_rst_n value for a given cycle
    task automatic expect_at(input int at, input bit val, input string req);
        exp_t e;
        e.at = at; e.val = val; e.req = req;
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // monitor: samples 2 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            checks++;
            if (sys_rst !== ~sys_rst_n) begin
                errors++;
                $display("FAIL R4 cyc=%0d sys_rst=%b expected=%b", cyc, sys_rst, ~sys_rst_n);
            end
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].at == cyc) begin
                    checks++;
                    if (sys_rst_n !== sb[i].val) begin
                        errors++;
                        $display("FAIL %s cyc=%0d sys_rst_n=%b expected=%b",
                                 sb[i].req, cyc, sys_rst_n, sb[i].val);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
        summary();
    end

    initial begin
        int c, c1, g;
        // R5: power-up reset holds reset, then a full interval follows
        @(negedge clk);
        expect_at(cyc, 1'b0, "R5");
        step(2);
        expect_at(cyc, 1'b0, "R5");
        rst = 1'b0;
        c = cyc;
        expect_at(c, 1'b0, "R5");
        expect_at(c + S - 1, 1'b0, "R3");
        expect_at(c + S, 1'b1, "R5");
        step(S + 3);
        expect_at(cyc, 1'b1, "R9");
        step(1);

        // R1 / R3: supply low asserts at once, releases after S edges
        c = cyc;
        supply_low = 1'b1;
        expect_at(c, 1'b0, "R1");
        step(5);
        supply_low = 1'b0;
        c = cyc;
        expect_at(c, 1'b0, "R3");
        expect_at(c + S - 1, 1'b0, "R3");
        expect_at(c + S, 1'b1, "R3");
        step(S + 2);

        // R2: manual low through the two-flop stage
        c = cyc;
        man_rst_n = 1'b0;
        expect_at(c, 1'b1, "R2");
        expect_at(c + 1, 1'b1, "R2");
        expect_at(c + 2, 1'b0, "R2");
        step(6);
        man_rst_n = 1'b1;
        c = cyc;
        expect_at(c + S + 1, 1'b0, "R3");
        expect_at(c + S + 2, 1'b1, "R3");
        step(S + 4);

        // R6: glitch during the interval restarts it
        man_rst_n = 1'b0;
        step(4);
        man_rst_n = 1'b1;
        c1 = cyc;
        step(8);
        g = cyc;
        man_rst_n = 1'b0;
        step(1);
        man_rst_n = 1'b1;
        expect_at(c1 + S + 2, 1'b0, "R6");
        expect_at(g + S + 2, 1'b0, "R6");
        expect_at(g + S + 3, 1'b1, "R6");
        step(S + 5);

        // R7: single-cycle pulse from the released state
        g = cyc;
        man_rst_n = 1'b0;
        expect_at(g + 1, 1'b1, "R7");
        expect_at(g + 2, 1'b0, "R7");
        step(1);
        man_rst_n = 1'b1;
        expect_at(g + S + 2, 1'b0, "R7");
        expect_at(g + S + 3, 1'b1, "R7");
        step(S + 5);

        // R8: supply clears first, manual last
        supply_low = 1'b1;
        man_rst_n = 1'b0;
        step(4);
        supply_low = 1'b0;
        c = cyc;
        step(6);
        man_rst_n = 1'b1;
        c1 = cyc;
        expect_at(c + S, 1'b0, "R8");
        expect_at(c1 + S + 1, 1'b0, "R8");
        expect_at(c1 + S + 2, 1'b1, "R8");
        step(S + 5);

        // R8: manual clears first, supply last
        man_rst_n = 1'b0;
        supply_low = 1'b1;
        step(4);
        man_rst_n = 1'b1;
        c1 = cyc;
        step(6);
        supply_low = 1'b0;
        c = cyc;
        expect_at(c1 + S + 2, 1'b0, "R8");
        expect_at(c + S - 1, 1'b0, "R8");
        expect_at(c + S, 1'b1, "R8");
        step(S + 5);

        // R9: stays released while idle
        step(30);
        expect_at(cyc, 1'b1, "R9");
        step(3);

        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard pending=%0d expected=0", sb.size());
        end
        summary();
    end
endmodule